// File: doc/BRIEF.md
# Compact Asynchronous Serial Port

This block is a small serial transmitter and receiver behind a word-indexed register bus laid out in the manner of a 16550. Each direction has an eight-entry queue. Frames are fixed at one start bit, seven or eight data bits sent least significant bit first, and one stop bit. There is no parity. The bit period is eight times a 16-bit divisor, counted in system clock cycles.

Software writes bytes into the transmit queue through the data register and pops received bytes through the same offset. It polls the line status register or uses the single interrupt output. The interrupt identify register reports which source is pending. Writing that register also empties either queue. Separate enable bits stop the receiver or the transmitter while the port is being reconfigured. A break bit holds the transmit line low. A software-driven request-to-send output, a readable clear-to-send input and a scratch byte complete the register set.

Top module: `mini_serial_port`

## Requirements
- R1: After reset, txd is 1, rts and irq are 0, the line status register (offset 5) reads 0x0060, interrupt identify (offset 2) reads 0x0001, line control (offset 3) reads 0x0003, extra control (offset 8) reads 0x0003, and baud (offset 10) reads the DIV_RESET parameter.
- R2: A byte written to offset 0 is sent on txd as a 0 start bit, then the data bits LSB first, then a 1 stop bit. Each bit lasts 8 × divisor clock cycles, and a divisor of 0 acts as 1.
- R3: When line control bits [1:0] equal 3, frames carry 8 data bits. Any other value gives 7 data bits, and in that mode a received byte reads with bit 7 equal to 0.
- R4: The receiver checks the start bit at its midpoint and samples each data bit at the centre of its period, LSB first. It queues the byte without checking the stop bit. Line status bit 0 is 1 while the receive queue holds data, and a read of offset 0 returns and pops the oldest byte.
- R5: The transmit queue holds 8 bytes in order. A write to offset 0 while it is full is dropped, and line status bit 5 is 1 only while the queue has room.
- R6: A byte that completes while the receive queue is full is discarded and sets line status bit 1. That bit stays set until line status is read, and a read clears it.
- R7: Interrupt enable (offset 1) bit 0 arms the receive source (receive queue not empty) and bit 1 arms the transmit source (transmit queue empty). Interrupt identify shows bit 2 for a pending receive source, otherwise bit 1 for a pending transmit source, otherwise bit 0 set. irq is 1 whenever a source is pending.
- R8: Writing interrupt identify with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue.
- R9: Extra control bit 0 enables the receiver and bit 1 the transmitter. A disabled receiver ignores the line, and a disabled transmitter starts no frame and leaves its queue untouched.
- R10: While line control bit 6 is 1, txd is 0. When it clears, txd returns to the frame or idle level.
- R11: Modem control bit 1 drives rts, modem status bit 5 follows the cts input, and the scratch register (offset 7) keeps 8 bits.
- R12: Bits without a function read back as 0 whatever was written, and writes to the status offsets (5, 6, 9) change nothing.
- R13: Line status bit 6 is 1 only when the transmit queue is empty and no frame is in progress. Extra status (offset 9) reports the receive level in bits [11:8] and the transmit level in bits [15:12].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (fires read side effects) |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for reg_addr |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear-to-send level |
| txd | output | 1 | Serial transmit line |
| rts | output | 1 | Request-to-send, set by software |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the length of a lone start bit and sends a 7-bit frame whose missing eighth bit would be 0. A design with a wrong period or a wrong bit count therefore shows a bad low-run length or a broken stop bit. It overfills both queues. A design that overwrites the oldest entry, keeps the ninth byte, or clears overrun without a status read returns the wrong byte sequence or the wrong status value. It sends a frame with a 0 stop bit, which a receiver that checks the stop bit would drop. It also changes the enables, the queue flushes and the break bit while data is pending, and a design that leaks through any of these gates puts unexpected frames on txd or bytes in the receive queue.

// File: rtl/msp_pkg.sv
// Shared definitions for the compact serial port: register word indices
// and the state encodings of the transmit and receive sequencers.
package msp_pkg;
    localparam logic [3:0] OFS_DATA = 4'd0;
    localparam logic [3:0] OFS_IEN  = 4'd1;
    localparam logic [3:0] OFS_IID  = 4'd2;
    localparam logic [3:0] OFS_LCTL = 4'd3;
    localparam logic [3:0] OFS_MCTL = 4'd4;
    localparam logic [3:0] OFS_LSTS = 4'd5;
    localparam logic [3:0] OFS_MSTS = 4'd6;
    localparam logic [3:0] OFS_SCR  = 4'd7;
    localparam logic [3:0] OFS_XCTL = 4'd8;
    localparam logic [3:0] OFS_XSTS = 4'd9;
    localparam logic [3:0] OFS_BAUD = 4'd10;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/msp_fifo.sv
// Synchronous first-in first-out queue with flush and fill level.
// Assumes: the caller never pushes when full nor pops when empty;
// flush has priority over a push or pop in the same cycle.
module msp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 din_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         full_o,
    output logic                         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Storage write: no reset needed, contents are qualified by count.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= din_i;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_i) - CW'(pop_i);
        end
    end

    assign head_o  = mem[rd_ptr];
    assign level_o = count;
    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/msp_tx.sv
// Transmit sequencer: pulls one byte from the queue when enabled and idle,
// sends start, 7 or 8 data bits LSB first, and stop, each 8*divisor cycles.
// Assumes: div_i and eight_i are stable during a frame (data size is
// latched at frame start); break overrides the line combinationally.
module msp_tx
    import msp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             eight_i,
    input  logic             brk_i,
    input  logic             empty_i,
    input  logic [DW-1:0]    data_i,
    output logic             pop_o,
    output logic             txd_o,
    output logic             idle_o
);
    localparam int CNT_W = DIV_W + 3;
    localparam int BC_W  = $clog2(DW + 1);

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [DW-1:0]     shreg;
    logic [BC_W-1:0]   left;
    logic              line;
    logic [DIV_W-1:0]  eff_div;
    logic [CNT_W-1:0]  period;
    logic              tick;

    assign eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
    assign period  = {eff_div, 3'b000};
    assign tick    = (cnt == period - CNT_W'(1));
    assign pop_o   = (state == TX_IDLE) && enable_i && !empty_i;

    // Frame sequencer: advances one bit per period and drives the line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            left  <= '0;
            line  <= 1'b1;
        end else begin
            case (state)
                TX_IDLE: begin
                    cnt  <= '0;
                    line <= 1'b1;
                    if (pop_o) begin
                        shreg <= data_i;
                        left  <= eight_i ? BC_W'(DW) : BC_W'(DW - 1);
                        line  <= 1'b0;
                        state <= TX_START;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        cnt   <= '0;
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                        left  <= left - BC_W'(1);
                        state <= TX_DATA;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        cnt <= '0;
                        if (left == '0) begin
                            line  <= 1'b1;
                            state <= TX_STOP;
                        end else begin
                            line  <= shreg[0];
                            shreg <= shreg >> 1;
                            left  <= left - BC_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        cnt   <= '0;
                        state <= TX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    assign txd_o  = line & ~brk_i;
    assign idle_o = (state == TX_IDLE);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |-> !txd_o);
    a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_STOP && !brk_i) |-> txd_o);
endmodule

// File: rtl/msp_rx.sv
// Receive sequencer: synchronises the line, confirms a start bit at its
// midpoint, samples data bits at bit centres LSB first, and emits a one-cycle
// push at the stop-bit centre without checking the stop level.
// Assumes: enable_i is only looked at while idle; a frame in progress completes.
module msp_rx
    import msp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             eight_i,
    input  logic             rxd_i,
    output logic             push_o,
    output logic [DW-1:0]    data_o,
    output logic             idle_o
);
    localparam int CNT_W = DIV_W + 3;
    localparam int BC_W  = $clog2(DW + 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [DW-1:0]     shreg;
    logic [BC_W-1:0]   left;
    logic              mode8;
    logic              sync1, rxs;
    logic              push_q;
    logic [DIV_W-1:0]  eff_div;
    logic [CNT_W-1:0]  period, half;
    logic              tick;

    assign eff_div = (div_i == '0) ? DIV_W'(1) : div_i;
    assign period  = {eff_div, 3'b000};
    assign half    = {1'b0, eff_div, 2'b00};
    assign tick    = (cnt == period - CNT_W'(1));

    // Two-flop synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            rxs   <= 1'b1;
        end else begin
            sync1 <= rxd_i;
            rxs   <= sync1;
        end
    end

    // Frame sequencer: start check, data sampling and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            left   <= '0;
            mode8  <= 1'b1;
            push_q <= 1'b0;
        end else begin
            push_q <= 1'b0;
            case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (enable_i && !rxs) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == half - CNT_W'(1)) begin
                        cnt <= '0;
                        if (!rxs) begin
                            left  <= eight_i ? BC_W'(DW) : BC_W'(DW - 1);
                            mode8 <= eight_i;
                            state <= RX_DATA;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        cnt   <= '0;
                        shreg <= {rxs, shreg[DW-1:1]};
                        left  <= left - BC_W'(1);
                        if (left == BC_W'(1)) state <= RX_STOP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        cnt    <= '0;
                        push_q <= 1'b1;
                        state  <= RX_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign push_o = push_q;
    assign data_o = mode8 ? shreg : {1'b0, shreg[DW-1:1]};
    assign idle_o = (state == RX_IDLE);

    a_r4_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
endmodule

// File: rtl/mini_serial_port.sv
// Compact serial port top: register file, interrupt logic, two queues and
// the transmit/receive sequencers.
// Assumes: BUS_W >= 16 and >= DIV_W; FIFO_DEPTH <= 15 so levels fit the
// 4-bit status fields; reg_rdata is combinational, reg_rd fires side effects.
module mini_serial_port
    import msp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 16,
    parameter int BUS_W      = 16,
    parameter int DIV_RESET  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             rxd,
    input  logic             cts,
    output logic             txd,
    output logic             rts,
    output logic             irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic [1:0]       ien;
    logic [1:0]       dsize;
    logic             brk;
    logic             rts_q;
    logic [7:0]       scratch;
    logic [1:0]       xctl;
    logic [DIV_W-1:0] baud;
    logic             overrun;

    logic [DW-1:0]    tx_head, rx_head, rx_byte;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_push, tx_pop, rx_push_raw, rx_push, rx_pop;
    logic             tx_flush, rx_flush;
    logic             tx_idle, rx_idle;
    logic             eight;
    logic             int_rx, int_tx;
    logic             wr_hit_iid, rd_hit_lsts;

    assign eight       = (dsize == 2'b11);
    assign wr_hit_iid  = reg_wr && (reg_addr == OFS_IID);
    assign rd_hit_lsts = reg_rd && (reg_addr == OFS_LSTS);
    assign rx_flush    = wr_hit_iid && reg_wdata[1];
    assign tx_flush    = wr_hit_iid && reg_wdata[2];
    assign tx_push     = reg_wr && (reg_addr == OFS_DATA) && !tx_full;
    assign rx_pop      = reg_rd && (reg_addr == OFS_DATA) && !rx_empty;
    assign rx_push     = rx_push_raw && !rx_full;

    // Software-visible control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 2'b00;
            dsize   <= 2'b11;
            brk     <= 1'b0;
            rts_q   <= 1'b0;
            scratch <= 8'h00;
            xctl    <= 2'b11;
            baud    <= DIV_W'(DIV_RESET);
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_IEN:  ien     <= reg_wdata[1:0];
                OFS_LCTL: begin
                    dsize <= reg_wdata[1:0];
                    brk   <= reg_wdata[6];
                end
                OFS_MCTL: rts_q   <= reg_wdata[1];
                OFS_SCR:  scratch <= reg_wdata[7:0];
                OFS_XCTL: xctl    <= reg_wdata[1:0];
                OFS_BAUD: baud    <= reg_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Overrun flag: set by a dropped byte, cleared by a line status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      overrun <= 1'b0;
        else if (rx_push_raw && rx_full) overrun <= 1'b1;
        else if (rd_hit_lsts)            overrun <= 1'b0;
    end

    msp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush_i(tx_flush),
        .push_i(tx_push), .din_i(reg_wdata[DW-1:0]), .pop_i(tx_pop),
        .head_o(tx_head), .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty)
    );

    msp_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush_i(rx_flush),
        .push_i(rx_push), .din_i(rx_byte), .pop_i(rx_pop),
        .head_o(rx_head), .level_o(rx_level), .full_o(rx_full), .empty_o(rx_empty)
    );

    msp_tx #(.DW(DW), .DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .enable_i(xctl[1]), .div_i(baud),
        .eight_i(eight), .brk_i(brk), .empty_i(tx_empty), .data_i(tx_head),
        .pop_o(tx_pop), .txd_o(txd), .idle_o(tx_idle)
    );

    msp_rx #(.DW(DW), .DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .enable_i(xctl[0]), .div_i(baud),
        .eight_i(eight), .rxd_i(rxd), .push_o(rx_push_raw), .data_o(rx_byte),
        .idle_o(rx_idle)
    );

    // Interrupt sources: receive takes precedence in the identify register.
    assign int_rx = ien[0] && !rx_empty;
    assign int_tx = ien[1] && tx_empty && !int_rx;
    assign irq    = int_rx || int_tx;
    assign rts    = rts_q;

    // Read multiplexer; unused bits stay 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DATA: reg_rdata[DW-1:0] = rx_head & {DW{!rx_empty}};
            OFS_IEN:  reg_rdata[1:0]    = ien;
            OFS_IID:  reg_rdata[2:0]    = {int_rx, int_tx, !irq};
            OFS_LCTL: begin
                reg_rdata[1:0] = dsize;
                reg_rdata[6]   = brk;
            end
            OFS_MCTL: reg_rdata[1]      = rts_q;
            OFS_LSTS: begin
                reg_rdata[0] = !rx_empty;
                reg_rdata[1] = overrun;
                reg_rdata[5] = !tx_full;
                reg_rdata[6] = tx_empty && tx_idle;
            end
            OFS_MSTS: reg_rdata[5]      = cts;
            OFS_SCR:  reg_rdata[7:0]    = scratch;
            OFS_XCTL: reg_rdata[1:0]    = xctl;
            OFS_XSTS: begin
                reg_rdata[0]          = !rx_empty;
                reg_rdata[1]          = !tx_full;
                reg_rdata[2]          = rx_idle;
                reg_rdata[3]          = tx_idle;
                reg_rdata[8 +: LVL_W]  = rx_level;
                reg_rdata[12 +: LVL_W] = tx_level;
            end
            OFS_BAUD: reg_rdata[DIV_W-1:0] = baud;
            default: ;
        endcase
    end

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push_raw && rx_full) |=> overrun);
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_hit_lsts) |=> overrun);
    a_r7_rx_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ien[0] && rx_level != '0) |-> irq);
    a_r9_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
        !xctl[1] |-> !tx_pop);
    a_r9_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!xctl[0] && rx_idle) |=> !rx_push_raw);
endmodule

// File: tb/test_mini_serial_port.sv
module test_mini_serial_port;
    localparam int DIV = 2;
    localparam int P   = 8 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rxd = 1'b1;
    logic        cts = 1'b0;
    logic        txd, rts, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mini_serial_port #(.DIV_RESET(7)) i_mini_serial_port (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rxd(rxd), .cts(cts), .txd(txd), .rts(rts), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Drive one frame on rxd: start, nbits data LSB first, stop level, idle gap.
    task automatic send_rx(input logic [7:0] b, input int nbits, input logic stop);
        @(negedge clk); rxd = 1'b0;
        repeat (P) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            rxd = b[i];
            repeat (P) @(negedge clk);
        end
        rxd = stop;
        repeat (P) @(negedge clk);
        rxd = 1'b1;
        repeat (P) @(negedge clk);
    endtask

    // Wait for a start bit on txd and sample each bit at its centre.
    task automatic capture_tx(input int nbits, output logic [7:0] b, output logic stop_ok);
        int w = 0;
        b = '0; stop_ok = 1'b0;
        while (txd !== 1'b0 && w < 40 * P) begin @(negedge clk); w++; end
        if (w >= 40 * P) return;
        repeat (P / 2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            repeat (P) @(negedge clk);
            b[i] = txd;
        end
        repeat (P) @(negedge clk);
        stop_ok = txd;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 txd idle", txd, 1);
        chk("R1 rts", rts, 0);
        chk("R1 irq", irq, 0);
        reg_read(4'd5, d);  chk("R1 line status", d, 16'h0060);
        reg_read(4'd2, d);  chk("R1 identify", d, 16'h0001);
        reg_read(4'd3, d);  chk("R1 line control", d, 16'h0003);
        reg_read(4'd8, d);  chk("R1 extra control", d, 16'h0003);
        reg_read(4'd10, d); chk("R1 baud", d, 16'd7);
        reg_write(4'd10, DIV);
    endtask

    task automatic t_tx_frames();
        logic [7:0] b; logic s; int n;
        reg_write(4'd0, 16'h0001);
        n = 0;
        while (txd !== 1'b0 && n < 40 * P) begin @(negedge clk); n++; end
        n = 0;
        while (txd === 1'b0 && n < 4 * P) begin n++; @(negedge clk); end
        chk("R2 start bit length", n, P);
        repeat (10 * P) @(negedge clk);
        reg_write(4'd0, 16'h00A5);
        capture_tx(8, b, s);
        chk("R2 byte A5", b, 8'hA5); chk("R2 stop A5", s, 1);
        reg_write(4'd0, 16'h003C);
        capture_tx(8, b, s);
        chk("R2 byte 3C", b, 8'h3C); chk("R2 stop 3C", s, 1);
        repeat (P) @(negedge clk);
    endtask

    task automatic t_seven_bit();
        logic [7:0] b; logic s; logic [15:0] d;
        reg_write(4'd3, 16'h0000);
        reg_write(4'd0, 16'h002A);
        capture_tx(7, b, s);
        chk("R3 7-bit tx data", b, 8'h2A); chk("R3 7-bit stop position", s, 1);
        repeat (P) @(negedge clk);
        send_rx(8'h55, 7, 1'b1);
        reg_read(4'd0, d); chk("R3 7-bit rx byte", d, 16'h0055);
        reg_write(4'd3, 16'h0003);
    endtask

    task automatic t_rx_basic();
        logic [15:0] d;
        send_rx(8'h96, 8, 1'b1);
        reg_read(4'd5, d); chk("R4 data ready", d[0], 1);
        reg_read(4'd0, d); chk("R4 rx byte 96", d, 16'h0096);
        reg_read(4'd5, d); chk("R4 queue drained", d[0], 0);
        send_rx(8'h3C, 8, 1'b0);
        reg_read(4'd0, d); chk("R4 stop not checked", d, 16'h003C);
        repeat (2 * P) @(negedge clk);
        reg_read(4'd5, d); chk("R4 no false byte", d[0], 0);
    endtask

    task automatic t_tx_fifo();
        logic [7:0] b; logic s; logic [15:0] d;
        reg_write(4'd8, 16'h0001);
        for (int i = 0; i < 9; i++) reg_write(4'd0, 16'h0010 + 16'(i));
        reg_read(4'd5, d); chk("R5 full no room", d[5], 0);
        chk("R13 busy not idle", d[6], 0);
        reg_read(4'd9, d); chk("R13 tx level", d[15:12], 8);
        reg_write(4'd8, 16'h0003);
        for (int i = 0; i < 8; i++) begin
            capture_tx(8, b, s);
            chk("R5 queued order", b, 8'h10 + 8'(i));
        end
        repeat (3 * P) @(negedge clk);
        reg_read(4'd5, d); chk("R5 ninth dropped, idle", d, 16'h0060);
    endtask

    task automatic t_overrun();
        logic [15:0] d;
        for (int i = 0; i < 9; i++) send_rx(8'h40 + 8'(i), 8, 1'b1);
        reg_read(4'd9, d); chk("R13 rx level", d[11:8], 8);
        reg_read(4'd5, d); chk("R6 overrun set", d, 16'h0063);
        reg_read(4'd5, d); chk("R6 overrun cleared by read", d, 16'h0061);
        for (int i = 0; i < 8; i++) begin
            reg_read(4'd0, d);
            chk("R6 kept bytes", d, 16'h0040 + 16'(i));
        end
        reg_read(4'd5, d); chk("R6 empty after", d[0], 0);
    endtask

    task automatic t_interrupts();
        logic [15:0] d;
        reg_write(4'd1, 16'h0003);
        reg_read(4'd2, d); chk("R7 tx source", d, 16'h0002);
        chk("R7 irq tx", irq, 1);
        send_rx(8'h11, 8, 1'b1);
        reg_read(4'd2, d); chk("R7 rx priority", d, 16'h0004);
        reg_write(4'd1, 16'h0000);
        reg_read(4'd2, d); chk("R7 none pending", d, 16'h0001);
        chk("R7 irq low", irq, 0);
        reg_write(4'd2, 16'h0002);
        reg_read(4'd5, d); chk("R8 rx flushed", d[0], 0);
        reg_write(4'd8, 16'h0001);
        reg_write(4'd0, 16'h0077);
        reg_write(4'd0, 16'h0078);
        reg_write(4'd2, 16'h0004);
        reg_read(4'd9, d); chk("R8 tx flushed level", d[15:12], 0);
        reg_read(4'd5, d); chk("R8 tx idle after flush", d[6], 1);
        reg_write(4'd8, 16'h0003);
        begin
            int lows = 0;
            for (int i = 0; i < 2 * P; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R8 nothing sent", lows, 0);
        end
    endtask

    task automatic t_enables();
        logic [15:0] d;
        reg_write(4'd8, 16'h0002);
        send_rx(8'h77, 8, 1'b1);
        reg_read(4'd5, d); chk("R9 rx disabled ignores line", d[0], 0);
        reg_write(4'd8, 16'h0001);
        reg_write(4'd0, 16'h0055);
        begin
            int lows = 0;
            for (int i = 0; i < 3 * P; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            chk("R9 tx disabled holds", lows, 0);
        end
        reg_read(4'd9, d); chk("R9 byte kept in queue", d[15:12], 1);
        reg_write(4'd8, 16'h0003);
        begin
            logic [7:0] b; logic s;
            capture_tx(8, b, s);
            chk("R9 released byte", b, 8'h55);
        end
        repeat (2 * P) @(negedge clk);
    endtask

    task automatic t_break();
        reg_write(4'd3, 16'h0043);
        chk("R10 break low", txd, 0);
        repeat (P) @(negedge clk);
        chk("R10 break held", txd, 0);
        reg_write(4'd3, 16'h0003);
        chk("R10 break released", txd, 1);
    endtask

    task automatic t_modem_misc();
        logic [15:0] d;
        reg_write(4'd4, 16'h0002); chk("R11 rts set", rts, 1);
        reg_write(4'd4, 16'h0000); chk("R11 rts clear", rts, 0);
        cts = 1'b1;
        reg_read(4'd6, d); chk("R11 cts high", d, 16'h0020);
        cts = 1'b0;
        reg_read(4'd6, d); chk("R11 cts low", d, 16'h0000);
        reg_write(4'd7, 16'hFFFF);
        reg_read(4'd7, d); chk("R11 scratch", d, 16'h00FF);
        reg_write(4'd7, 16'h005A);
        reg_read(4'd7, d); chk("R11 scratch pattern", d, 16'h005A);
    endtask

    task automatic t_unsupported();
        logic [15:0] d;
        reg_write(4'd1, 16'hFFFF);
        reg_read(4'd1, d); chk("R12 enable bits", d, 16'h0003);
        reg_write(4'd1, 16'h0000);
        reg_write(4'd4, 16'hFFFF);
        reg_read(4'd4, d); chk("R12 modem control bits", d, 16'h0002);
        reg_write(4'd4, 16'h0000);
        reg_write(4'd3, 16'hFFFF);
        reg_read(4'd3, d); chk("R12 line control bits", d, 16'h0043);
        reg_write(4'd3, 16'h0003);
        reg_write(4'd8, 16'hFFFF);
        reg_read(4'd8, d); chk("R12 extra control bits", d, 16'h0003);
        reg_write(4'd5, 16'hFFFF);
        reg_read(4'd5, d); chk("R12 status write ignored", d, 16'h0060);
        reg_write(4'd6, 16'hFFFF);
        reg_read(4'd6, d); chk("R12 modem status write ignored", d, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_frames();
        t_seven_bit();
        t_rx_basic();
        t_tx_fifo();
        t_overrun();
        t_interrupts();
        t_enables();
        t_break();
        t_modem_misc();
        t_unsupported();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule